// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Status Flags

This block is the receive half of a clock-synchronous serial port. An external serial clock and data line come into the system clock domain through a synchronizer. On every rising serial clock edge one data bit is shifted in, least significant bit first. When the eighth bit of a frame arrives, the frame is moved into a receive data register. A status register then reports that data is waiting.

Software reads the received frames over a simple register bus. It polls or takes an interrupt on each new frame, reads the data, and clears the data-full flag by writing a 0 to it. If software falls behind, the next completed frame sets an overrun flag instead of overwriting the data, and reception freezes until software clears that flag. Two more error flags are shared with an asynchronous receiver that sits outside this block: a framing flag and a parity flag. While either of them is set, reception is also held off. Clearing the enable bit ends reception and throws away any partly received frame.

Top module: `sio_rx`

## Requirements
- R1: After reset, the data register reads 0x00, status reads 0x00, control reads 0x00 and `rxi_o` is 0.
- R2: Frames are 8 bits, sampled on rising `sclk_i` edges, first bit into bit 0. The completed frame is readable at address 0.
- R3: When a frame completes with the full flag clear, status bit 0 (full) is set. `rxi_o` pulses high for exactly one system clock on each 0-to-1 change of full.
- R4: Reading the data register leaves the full flag set.
- R5: Writing to status (address 1) clears each flag whose bit is written 0. A bit written 1 leaves its flag as it was.
- R6: If full is still 1 when the eighth bit of the next frame arrives, status bit 1 (overrun) is set and the data register keeps its old value.
- R7: While overrun is 1, serial clock edges are ignored. Reception restarts from a fresh frame only after overrun is written 0.
- R8: While the framing flag (status bit 2, set by a `fer_set_i` pulse) or the parity flag (status bit 3, set by a `per_set_i` pulse) is 1, full is not set and no reception takes place.
- R9: With the enable bit (control address 2, bit 0) at 0, the bit counter is held at zero and serial edges are ignored. A partial frame is discarded when the enable bit is cleared.
- R10: Reading the data and clearing full before the eighth bit of the frame in progress arrives gives continuous reception with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | External serial clock, asynchronous to `clk_i` |
| sdata_i | input | 1 | Serial data, sampled on rising `sclk_i` |
| addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |
| fer_set_i | input | 1 | Pulse that sets the framing error flag |
| per_set_i | input | 1 | Pulse that sets the parity error flag |
| rxi_o | output | 1 | Receive interrupt, one-cycle pulse |

## Verification
A rising edge on `sclk_i` passes through two synchronizer flops and then one register stage. The shifted bit, the loaded data, the full and overrun flags and the `rxi_o` pulse therefore all change on the third system clock edge after the serial edge. The bench holds each serial clock phase for four system cycles, so by the next serial phase every result of the previous edge is already in place. Results are sampled on the falling edge of the system clock. Register writes and flag pulses take effect on the next rising edge, and reads are combinational, so each check after a write comes one full cycle later. Interrupt pulses are counted on every rising edge, and each frame must add exactly one.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_FER  = 2;
  localparam int ST_PER  = 3;
  localparam int CT_EN   = 0;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES:0]   clk_pipe_q;
  logic [STAGES-1:0] dat_pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_pipe_q <= '0;
      dat_pipe_q <= '0;
    end else begin
      clk_pipe_q <= {clk_pipe_q[STAGES-1:0], sclk_i};
      dat_pipe_q <= {dat_pipe_q[STAGES-2:0], sdata_i};
    end
  end

  // data is delayed to line up with the detected edge
  assign rise_o = clk_pipe_q[STAGES-1] & ~clk_pipe_q[STAGES];
  assign bit_o  = dat_pipe_q[STAGES-1];
endmodule

// File: rtl/sio_rx_shift.sv
module sio_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [DATA_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (!active_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (rise_i) begin
      shreg_q <= {bit_i, shreg_q[DATA_W-1:1]};
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign done_o  = active_i & rise_i & (cnt_q == LAST);
  assign frame_o = {bit_i, shreg_q[DATA_W-1:1]};

  AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);  // R9
endmodule

// File: rtl/sio_rx_regs.sv
module sio_rx_regs
  import sio_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              fer_set_i,
  input  logic              per_set_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] frame_i,
  output logic              active_o,
  output logic              rxi_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, ovr_q, fer_q, per_q, en_q, rxi_q;
  logic wr_stat, wr_ctrl, load, overrun;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[7:4];
  assign wr_stat = wr_en_i && addr_i == ADDR_STAT;
  assign wr_ctrl = wr_en_i && addr_i == ADDR_CTRL;
  assign load    = done_i & ~full_q;
  assign overrun = done_i & full_q;
  assign active_o = en_q & ~(ovr_q | fer_q | per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
      en_q   <= 1'b0;
      rxi_q  <= 1'b0;
    end else begin
      rxi_q <= load;
      if (load) data_q <= frame_i;
      // hardware set wins over a software clear in the same cycle
      if (load)                              full_q <= 1'b1;
      else if (wr_stat && !wdata_i[ST_FULL]) full_q <= 1'b0;
      if (overrun)                           ovr_q <= 1'b1;
      else if (wr_stat && !wdata_i[ST_OVR])  ovr_q <= 1'b0;
      if (fer_set_i)                         fer_q <= 1'b1;
      else if (wr_stat && !wdata_i[ST_FER])  fer_q <= 1'b0;
      if (per_set_i)                         per_q <= 1'b1;
      else if (wr_stat && !wdata_i[ST_PER])  per_q <= 1'b0;
      if (wr_ctrl) en_q <= wdata_i[CT_EN];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_DATA: rdata_o = 8'(data_q);
      ADDR_STAT: begin
        rdata_o[ST_FULL] = full_q;
        rdata_o[ST_OVR]  = ovr_q;
        rdata_o[ST_FER]  = fer_q;
        rdata_o[ST_PER]  = per_q;
      end
      ADDR_CTRL: rdata_o[CT_EN] = en_q;
      default:   rdata_o = '0;
    endcase
  end

  assign rxi_o = rxi_q;

  AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxi_q |-> full_q && !$past(full_q));  // R3
  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> $stable(data_q));  // R6
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(full_q));  // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !(wr_stat && !wdata_i[ST_OVR]) |=> ovr_q);  // R7
  AST_ERR_BLOCKS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fer_q || per_q) && !full_q |=> !full_q);  // R8
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdata_i,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       fer_set_i,
  input  logic       per_set_i,
  output logic       rxi_o
);
  logic rise, sbit, active, done;
  logic [DATA_W-1:0] frame;

  sio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .rise_o(rise), .bit_o(sbit)
  );

  sio_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .rise_i(rise),
    .bit_i(sbit), .done_o(done), .frame_o(frame)
  );

  sio_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .fer_set_i(fer_set_i),
    .per_set_i(per_set_i), .done_i(done), .frame_i(frame),
    .active_o(active), .rxi_o(rxi_o)
  );
endmodule

// File: tb/sio_rx_bench.sv
module sio_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wr_en = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic fer_set = 1'b0, per_set = 1'b0;
  logic rxi;
  int errors = 0, checks = 0, irq_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sio_rx u_sio_rx (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .fer_set_i(fer_set), .per_set_i(per_set), .rxi_o(rxi)
  );

  always @(posedge clk) if (rxi) irq_cnt++;

  localparam logic [7:0] VEC [0:5] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); sdata = b; sclk = 1'b0;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  initial begin
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); chk("R1 data", d, 8'h00);
    rd(2'd1, d); chk("R1 status", d, 8'h00);
    rd(2'd2, d); chk("R1 ctrl", d, 8'h00);
    chk("R1 rxi", {7'b0, rxi}, 8'h00);

    // R9: disabled receiver ignores edges
    send_bits(8'h5A, 8);
    rd(2'd1, d); chk("R9 disabled no full", d, 8'h00);
    wr(2'd2, 8'h01);

    for (int k = 0; k < 6; k++) begin
      base = irq_cnt;
      send_bits(VEC[k], 8);
      rd(2'd0, d); chk("R2 frame", d, VEC[k]);
      rd(2'd1, d); chk("R3 full", d, 8'h01);
      chk("R3 one irq pulse", 8'(irq_cnt - base), 8'd1);
      rd(2'd0, d); rd(2'd1, d); chk("R4 read keeps full", d, 8'h01);
      wr(2'd1, 8'hFF);
      rd(2'd1, d); chk("R5 write 1 keeps", d, 8'h01);
      wr(2'd1, 8'hFE);
      rd(2'd1, d); chk("R5 write 0 clears", d, 8'h00);
    end

    // R6: overrun keeps old data
    send_bits(8'h11, 8);
    base = irq_cnt;
    send_bits(8'h22, 8);
    rd(2'd1, d); chk("R6 overrun flag", d, 8'h03);
    rd(2'd0, d); chk("R6 data kept", d, 8'h11);
    chk("R6 no irq", 8'(irq_cnt - base), 8'd0);
    // R7: frozen while overrun set
    wr(2'd1, 8'hFE);
    send_bits(8'h33, 8);
    rd(2'd1, d); chk("R7 halted", d, 8'h02);
    rd(2'd0, d); chk("R7 data unchanged", d, 8'h11);
    wr(2'd1, 8'hFD);
    send_bits(8'h44, 8);
    rd(2'd0, d); chk("R7 resumed", d, 8'h44);
    rd(2'd1, d); chk("R7 status", d, 8'h01);
    wr(2'd1, 8'hFE);

    // R8: framing then parity flags block reception
    @(negedge clk); fer_set = 1'b1; @(negedge clk); fer_set = 1'b0;
    send_bits(8'h55, 8);
    rd(2'd1, d); chk("R8 fer blocks", d, 8'h04);
    rd(2'd0, d); chk("R8 fer data", d, 8'h44);
    wr(2'd1, 8'hFB);
    @(negedge clk); per_set = 1'b1; @(negedge clk); per_set = 1'b0;
    send_bits(8'h66, 8);
    rd(2'd1, d); chk("R8 per blocks", d, 8'h08);
    wr(2'd1, 8'hF7);
    send_bits(8'h77, 8);
    rd(2'd0, d); chk("R8 resumed", d, 8'h77);
    wr(2'd1, 8'hFE);

    // R9: partial frame discarded on disable
    send_bits(8'h0F, 4);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
    send_bits(8'hC3, 8);
    rd(2'd0, d); chk("R9 fresh frame", d, 8'hC3);
    wr(2'd1, 8'hFE);

    // R10: clear before last bit of next frame
    send_bits(8'h9A, 8);
    send_bits(8'hB6, 7);
    rd(2'd0, d); chk("R10 first frame", d, 8'h9A);
    wr(2'd1, 8'hFE);
    send_bit(1'b1);
    rd(2'd1, d); chk("R10 no overrun", d, 8'h01);
    rd(2'd0, d); chk("R10 second frame", d, 8'hB6);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule